// File: doc/BRIEF.md
# I2C Target Byte-Level Controller

This block runs the byte-level side of an I2C target. Below it sits a bit engine. That engine decodes the address and shifts bits, and it raises one-cycle event strobes: address matched, byte received, transmit holding register empty, NACK seen from the bus controller, and STOP seen. On the host side the block takes two requests. A receive arm request carries a buffer capacity. A transmit request is either a packet of a given length, read from host memory through an index/data port, or one fill byte that is repeated for as long as the bus controller keeps reading.

The block tracks each direction separately, with an armed state and an active state for each. Received bytes go out through a write port. When the bus controller turns the bus around, the block holds SCL low until the host supplies reply data. At the end of a transfer it reports the byte count for that direction in a one-cycle completion pulse. It also drives the ACK enable of the bit engine.

All outputs except `tx_rd_idx_o` are registered. A response appears in the cycle after the event or request that caused it. When strobes arrive in the same cycle, the priority is STOP, then NACK, then address match, then received byte, then transmit-empty. Any bit-engine strobe drops a host request made in that same cycle. A receive arm request beats a transmit request.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the block is idle. `ack_en_o`, `byte_evt_en_o`, `scl_hold_o` and every pulse output are 0.
- R2: A receive arm request sets `ack_en_o` to 1, clears `byte_evt_en_o` and `scl_hold_o`, latches the capacity and clears the receive offset.
- R3: An address match while armed for receive sets `byte_evt_en_o` to 1. An address match while idle has no effect on `byte_evt_en_o`.
- R4: While receiving, each received byte is written through the write port at index equal to the current offset, and the offset then increments. When the offset equals the capacity, the byte is not written and `ack_en_o` drops to 0.
- R5: A transmit-empty event while receiving pulses `rx_done_o` with the receive count and clears the offset. It also drops `ack_en_o` and `byte_evt_en_o` and raises `scl_hold_o`.
- R6: A transmit request while waiting for reply data does three things one cycle later: it releases `scl_hold_o`, sets `byte_evt_en_o`, and pulses `tx_load_o` with the first byte.
- R7: A transmit request in idle, receive-armed or transmitting state only preloads the data. No byte is loaded until the next transmit-empty event.
- R8: A transmit request while receiving pulses `tx_refused_o` and changes neither `scl_hold_o` nor `ack_en_o`.
- R9: In fill-byte mode, every transmit-empty event loads the same byte and adds one to the sent count.
- R10: In packet mode, transmit-empty events load bytes at index 0 to length-1. When the length is used up, the next event instead pulses `tx_done_o` with the length and raises `scl_hold_o`. A length-0 request made while waiting for reply data pulses `tx_done_o` with count 0.
- R11: A NACK while transmitting pulses `tx_done_o` with the loaded count minus one and sets `ack_en_o`. It clears `scl_hold_o` and `byte_evt_en_o` and returns the block to receive-armed. A NACK in any other state has no effect.
- R12: A STOP pulses `rx_done_o` with the receive offset, clears the offset, sets `ack_en_o`, clears `scl_hold_o` and returns the block to receive-armed.
- R13: `rx_done_o` and `tx_done_o` last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_addr_i | input | 1 | Bit engine: own address matched |
| ev_rx_byte_i | input | 1 | Bit engine: byte received |
| rx_data_i | input | 8 | Received byte |
| ev_tx_empty_i | input | 1 | Bit engine: transmit holding register empty |
| ev_nack_i | input | 1 | Bit engine: NACK from bus controller |
| ev_stop_i | input | 1 | Bit engine: STOP seen |
| rx_arm_i | input | 1 | Host: arm receive |
| rx_cap_i | input | IDX_W+1 | Receive buffer capacity |
| tx_req_i | input | 1 | Host: transmit request |
| tx_fill_i | input | 1 | 1 = repeated fill byte, 0 = packet |
| tx_len_i | input | IDX_W+1 | Packet length |
| tx_byte_i | input | 8 | Fill byte |
| tx_rd_idx_o | output | IDX_W | Packet read index (combinational) |
| tx_rd_data_i | input | 8 | Packet byte at tx_rd_idx_o |
| ack_en_o | output | 1 | ACK enable to bit engine |
| byte_evt_en_o | output | 1 | Per-byte event enable |
| scl_hold_o | output | 1 | Hold SCL low (clock stretch) |
| tx_load_o | output | 1 | Load tx_data_o into the bit engine |
| tx_data_o | output | 8 | Byte to transmit |
| rx_wr_en_o | output | 1 | Receive write strobe |
| rx_wr_idx_o | output | IDX_W | Receive write index |
| rx_wr_data_o | output | 8 | Receive write data |
| rx_done_o | output | 1 | Receive completion pulse |
| rx_count_o | output | IDX_W+1 | Bytes received |
| tx_done_o | output | 1 | Transmit completion pulse |
| tx_count_o | output | IDX_W+1 | Bytes sent |
| tx_refused_o | output | 1 | Transmit request refused (busy) |

## Verification
The bench runs write then read transactions in which the capacity, the number of bytes and the received data are all random. The byte count is sometimes below the capacity and sometimes above it, which tells storage apart from overflow NACKing. Each transaction ends in one of two ways: a STOP, or a turnaround followed by a fill-byte or packet reply of random length. The number of transmit-empty events runs past the end of the packet on some runs, so a NACK-corrected count can be told apart from a length-exhausted completion. Directed cases cover three more points: an address match while idle, a request that is refused while receiving, and a request that only preloads the data.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C target byte-level controller.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        TS_IDLE,
        TS_RX_ARMED,
        TS_RX,
        TS_TX_ARMED,
        TS_TX
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_fsm.sv
// Direction state machine. It ranks the bit-engine strobes, decides what the
// receive and transmit units do, and drives ACK enable, the per-byte event
// enable and the clock-stretch hold.
// Assumes one-cycle strobes. When strobes coincide, STOP wins over NACK,
// NACK over address, address over received byte, and received byte over
// transmit-empty. Any strobe drops a host request in the same cycle.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_addr,
    input  logic ev_rx_byte,
    input  logic ev_tx_empty,
    input  logic ev_nack,
    input  logic ev_stop,
    input  logic rx_arm,
    input  logic tx_req,
    input  logic rx_full,
    input  logic tx_end,
    output logic act_rx_open,
    output logic act_rx_store,
    output logic act_rx_close,
    output logic act_tx_accept,
    output logic act_tx_kick,
    output logic act_tx_step,
    output logic act_tx_nack,
    output logic ack_en,
    output logic evt_en,
    output logic hold,
    output logic refused
);
    tgt_state_t st, st_n;
    logic ack_n, evt_n, hold_n;
    logic any_ev, host_ok;
    logic e_stop, e_nack, e_addr, e_rxb, e_txe;
    logic refuse;

    // Rank the strobes by priority and decode the unit actions.
    always_comb begin
        any_ev  = ev_addr | ev_rx_byte | ev_tx_empty | ev_nack | ev_stop;
        host_ok = !any_ev;
        e_stop  = ev_stop;
        e_nack  = ev_nack & !ev_stop;
        e_addr  = ev_addr & !ev_stop & !ev_nack;
        e_rxb   = ev_rx_byte & !(ev_stop | ev_nack | ev_addr);
        e_txe   = ev_tx_empty & !(ev_stop | ev_nack | ev_addr | ev_rx_byte);
        act_rx_open   = rx_arm & host_ok;
        act_tx_accept = tx_req & host_ok & !rx_arm & (st != TS_RX);
        refuse        = tx_req & host_ok & !rx_arm & (st == TS_RX);
        act_tx_kick   = act_tx_accept & (st == TS_TX_ARMED);
        act_rx_store  = e_rxb & (st == TS_RX);
        act_rx_close  = e_stop | (e_txe & (st == TS_RX));
        act_tx_step   = e_txe & (st == TS_TX);
        act_tx_nack   = e_nack & (st == TS_TX);
    end

    // Next-state and next-output selection.
    always_comb begin
        st_n   = st;
        ack_n  = ack_en;
        evt_n  = evt_en;
        hold_n = hold;
        if (e_stop) begin
            st_n = TS_RX_ARMED; ack_n = 1'b1; evt_n = 1'b0; hold_n = 1'b0;
        end else if (e_nack) begin
            if (st == TS_TX) begin
                st_n = TS_RX_ARMED; ack_n = 1'b1; evt_n = 1'b0; hold_n = 1'b0;
            end
        end else if (e_addr) begin
            if (st == TS_RX_ARMED) begin
                st_n = TS_RX; evt_n = 1'b1;
            end else if (st == TS_TX) begin
                evt_n = 1'b1;
            end
        end else if (e_rxb) begin
            if (st == TS_RX && rx_full) ack_n = 1'b0;
        end else if (e_txe) begin
            if (st == TS_RX) begin
                st_n = TS_TX_ARMED; ack_n = 1'b0; evt_n = 1'b0; hold_n = 1'b1;
            end else if (st == TS_TX && tx_end) begin
                st_n = TS_TX_ARMED; evt_n = 1'b0; hold_n = 1'b1;
            end
        end else if (act_rx_open) begin
            st_n = TS_RX_ARMED; ack_n = 1'b1; evt_n = 1'b0; hold_n = 1'b0;
        end else if (act_tx_kick) begin
            if (!tx_end) begin
                st_n = TS_TX; evt_n = 1'b1; hold_n = 1'b0;
            end
        end else if (act_tx_accept) begin
            st_n = TS_TX;
        end
    end

    // State and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TS_IDLE;
            ack_en  <= 1'b0;
            evt_en  <= 1'b0;
            hold    <= 1'b0;
            refused <= 1'b0;
        end else begin
            st      <= st_n;
            ack_en  <= ack_n;
            evt_en  <= evt_n;
            hold    <= hold_n;
            refused <= refuse;
        end
    end
endmodule

// File: rtl/i2c_tgt_rx.sv
// Receive unit: holds the capacity and the offset, writes stored bytes out
// through the write port and reports the count when reception is closed.
// Assumes the FSM never asserts open together with store or close.
module i2c_tgt_rx #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic [IDX_W:0]   cap_i,
    input  logic             store_i,
    input  logic             close_i,
    input  logic [7:0]       data_i,
    output logic             full_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             done_o,
    output logic [IDX_W:0]   count_o
);
    localparam int CNT_W = IDX_W + 1;
    logic [CNT_W-1:0] cap, off;

    // The buffer is full once the offset reaches the capacity.
    always_comb full_o = (off >= cap);

    // Offset tracking, byte write-out and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap       <= '0;
            off       <= '0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
            done_o    <= 1'b0;
            count_o   <= '0;
        end else begin
            wr_en_o <= 1'b0;
            done_o  <= 1'b0;
            if (open_i) begin
                cap <= cap_i;
                off <= '0;
            end
            if (store_i && !full_o) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= IDX_W'(off);
                wr_data_o <= data_i;
                off       <= off + CNT_W'(1);
            end
            if (close_i) begin
                done_o  <= 1'b1;
                count_o <= off;
                off     <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_tx.sv
// Transmit unit: latches a request (fill byte or packet), supplies the next
// byte on each kick or step, and reports the count when the data runs out or
// a NACK arrives. On a NACK it takes one off the count, because the last
// loaded byte was never shifted out.
// Assumes a kick always comes with accept in the same cycle.
module i2c_tgt_tx #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             kick_i,
    input  logic             step_i,
    input  logic             nack_i,
    input  logic             req_fill_i,
    input  logic [IDX_W:0]   req_len_i,
    input  logic [7:0]       req_byte_i,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [7:0]       rd_data_i,
    output logic             end_o,
    output logic             load_o,
    output logic [7:0]       data_o,
    output logic             done_o,
    output logic [IDX_W:0]   count_o
);
    localparam int CNT_W = IDX_W + 1;
    logic             fill;
    logic [7:0]       fbyte;
    logic [CNT_W-1:0] len, off;
    logic             s_fill;
    logic [7:0]       s_byte;
    logic [CNT_W-1:0] s_len, s_off;
    logic             have;

    // A kick uses the request fields directly; a step uses the latched ones.
    always_comb begin
        s_fill   = kick_i ? req_fill_i : fill;
        s_byte   = kick_i ? req_byte_i : fbyte;
        s_len    = kick_i ? req_len_i  : len;
        s_off    = kick_i ? '0         : off;
        have     = s_fill || (s_off < s_len);
        end_o    = (kick_i || step_i) && !have;
        rd_idx_o = IDX_W'(s_off);
    end

    // Request latch, byte loading and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill    <= 1'b0;
            fbyte   <= '0;
            len     <= '0;
            off     <= '0;
            load_o  <= 1'b0;
            data_o  <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else begin
            load_o <= 1'b0;
            done_o <= 1'b0;
            if (accept_i) begin
                fill  <= req_fill_i;
                fbyte <= req_byte_i;
                len   <= req_len_i;
                off   <= '0;
            end
            if (kick_i || step_i) begin
                if (have) begin
                    load_o <= 1'b1;
                    data_o <= s_fill ? s_byte : rd_data_i;
                    off    <= s_off + CNT_W'(1);
                end else begin
                    done_o  <= 1'b1;
                    count_o <= s_off;
                end
            end
            if (nack_i) begin
                done_o  <= 1'b1;
                count_o <= (off == '0) ? '0 : off - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Top of the I2C target byte-level controller. It ties the direction FSM to
// the receive and transmit units. Every output except tx_rd_idx_o is
// registered, so a response appears one cycle after its cause.
// Assumes bit-engine strobes last one cycle and host memory answers
// tx_rd_idx_o combinationally.
module i2c_tgt_ctrl #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_addr_i,
    input  logic             ev_rx_byte_i,
    input  logic [7:0]       rx_data_i,
    input  logic             ev_tx_empty_i,
    input  logic             ev_nack_i,
    input  logic             ev_stop_i,
    input  logic             rx_arm_i,
    input  logic [IDX_W:0]   rx_cap_i,
    input  logic             tx_req_i,
    input  logic             tx_fill_i,
    input  logic [IDX_W:0]   tx_len_i,
    input  logic [7:0]       tx_byte_i,
    output logic [IDX_W-1:0] tx_rd_idx_o,
    input  logic [7:0]       tx_rd_data_i,
    output logic             ack_en_o,
    output logic             byte_evt_en_o,
    output logic             scl_hold_o,
    output logic             tx_load_o,
    output logic [7:0]       tx_data_o,
    output logic             rx_wr_en_o,
    output logic [IDX_W-1:0] rx_wr_idx_o,
    output logic [7:0]       rx_wr_data_o,
    output logic             rx_done_o,
    output logic [IDX_W:0]   rx_count_o,
    output logic             tx_done_o,
    output logic [IDX_W:0]   tx_count_o,
    output logic             tx_refused_o
);
    logic a_rx_open, a_rx_store, a_rx_close;
    logic a_tx_accept, a_tx_kick, a_tx_step, a_tx_nack;
    logic rx_full, tx_end;

    i2c_tgt_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .ev_addr(ev_addr_i), .ev_rx_byte(ev_rx_byte_i),
        .ev_tx_empty(ev_tx_empty_i), .ev_nack(ev_nack_i), .ev_stop(ev_stop_i),
        .rx_arm(rx_arm_i), .tx_req(tx_req_i),
        .rx_full(rx_full), .tx_end(tx_end),
        .act_rx_open(a_rx_open), .act_rx_store(a_rx_store),
        .act_rx_close(a_rx_close), .act_tx_accept(a_tx_accept),
        .act_tx_kick(a_tx_kick), .act_tx_step(a_tx_step),
        .act_tx_nack(a_tx_nack),
        .ack_en(ack_en_o), .evt_en(byte_evt_en_o), .hold(scl_hold_o),
        .refused(tx_refused_o)
    );

    i2c_tgt_rx #(.IDX_W(IDX_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .open_i(a_rx_open), .cap_i(rx_cap_i),
        .store_i(a_rx_store), .close_i(a_rx_close), .data_i(rx_data_i),
        .full_o(rx_full),
        .wr_en_o(rx_wr_en_o), .wr_idx_o(rx_wr_idx_o), .wr_data_o(rx_wr_data_o),
        .done_o(rx_done_o), .count_o(rx_count_o)
    );

    i2c_tgt_tx #(.IDX_W(IDX_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .accept_i(a_tx_accept), .kick_i(a_tx_kick),
        .step_i(a_tx_step), .nack_i(a_tx_nack),
        .req_fill_i(tx_fill_i), .req_len_i(tx_len_i), .req_byte_i(tx_byte_i),
        .rd_idx_o(tx_rd_idx_o), .rd_data_i(tx_rd_data_i),
        .end_o(tx_end),
        .load_o(tx_load_o), .data_o(tx_data_o),
        .done_o(tx_done_o), .count_o(tx_count_o)
    );
endmodule

// File: rtl/i2c_tgt_ctrl_chk.sv
// Temporal checks on the top-level ports of the I2C target controller.
module i2c_tgt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ev_rx_byte_i,
    input logic ev_tx_empty_i,
    input logic ev_nack_i,
    input logic ev_stop_i,
    input logic tx_req_i,
    input logic ack_en_o,
    input logic scl_hold_o,
    input logic tx_load_o,
    input logic rx_wr_en_o,
    input logic rx_done_o,
    input logic tx_done_o,
    input logic tx_refused_o
);
    // A receive write only follows a received-byte strobe.
    assert_rx_write_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_en_o |-> $past(ev_rx_byte_i));

    // The clock hold starts only after a transmit-empty strobe.
    assert_hold_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> $past(ev_tx_empty_i));

    // A byte is never loaded while SCL is being held.
    assert_load_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> !scl_hold_o);

    // A refusal answers a request and loads nothing.
    assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_refused_o |-> ($past(tx_req_i) && !tx_load_o));

    // A transmit completion caused by a NACK re-enables ACK.
    assert_nack_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_o && $past(ev_nack_i)) |-> ack_en_o);

    // After a STOP, ACK is on and SCL is free.
    assert_stop_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_stop_i) |-> (ack_en_o && !scl_hold_o && rx_done_o));

    // The two completion pulses never coincide.
    assert_single_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_done_o && tx_done_o));

    // Completion pulses last exactly one cycle.
    assert_pulse_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_o || tx_done_o) |=> !(rx_done_o || tx_done_o));
endmodule

bind i2c_tgt_ctrl i2c_tgt_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_byte_i(ev_rx_byte_i), .ev_tx_empty_i(ev_tx_empty_i),
    .ev_nack_i(ev_nack_i), .ev_stop_i(ev_stop_i), .tx_req_i(tx_req_i),
    .ack_en_o(ack_en_o), .scl_hold_o(scl_hold_o), .tx_load_o(tx_load_o),
    .rx_wr_en_o(rx_wr_en_o), .rx_done_o(rx_done_o), .tx_done_o(tx_done_o),
    .tx_refused_o(tx_refused_o)
);

// File: tb/i2c_tgt_ctrl_tb_top.sv
// Bench for the I2C target controller. Directed corner cases come first,
// then randomized transactions with a fixed seed.
module i2c_tgt_ctrl_tb_top;
    localparam int IDX_W = 5;
    localparam int K_ADDR = 0, K_RXB = 1, K_TXE = 2, K_NACK = 3, K_STOP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_addr_i = 0, ev_rx_byte_i = 0, ev_tx_empty_i = 0, ev_nack_i = 0, ev_stop_i = 0;
    logic [7:0] rx_data_i = '0;
    logic rx_arm_i = 0, tx_req_i = 0, tx_fill_i = 0;
    logic [IDX_W:0] rx_cap_i = '0, tx_len_i = '0;
    logic [7:0] tx_byte_i = '0;
    logic [IDX_W-1:0] tx_rd_idx_o;
    logic [7:0] tx_rd_data_i;
    logic ack_en_o, byte_evt_en_o, scl_hold_o, tx_load_o, rx_wr_en_o;
    logic [7:0] tx_data_o, rx_wr_data_o;
    logic [IDX_W-1:0] rx_wr_idx_o;
    logic rx_done_o, tx_done_o, tx_refused_o;
    logic [IDX_W:0] rx_count_o, tx_count_o;

    logic [7:0] txmem [32];
    int nerr = 0, nchk = 0;
    bit finished = 0;

    assign tx_rd_data_i = txmem[tx_rd_idx_o];

    always #10 clk = ~clk;

    i2c_tgt_ctrl #(.IDX_W(IDX_W)) dut_i (.*);

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pulse one bit-engine strobe for a cycle; return at the next negedge.
    task automatic ev(input int k, input logic [7:0] d = 8'h00);
        @(negedge clk);
        rx_data_i = d;
        case (k)
            K_ADDR:  ev_addr_i = 1;
            K_RXB:   ev_rx_byte_i = 1;
            K_TXE:   ev_tx_empty_i = 1;
            K_NACK:  ev_nack_i = 1;
            default: ev_stop_i = 1;
        endcase
        @(negedge clk);
        ev_addr_i = 0; ev_rx_byte_i = 0; ev_tx_empty_i = 0; ev_nack_i = 0; ev_stop_i = 0;
    endtask

    task automatic arm(input int cap);
        @(negedge clk);
        rx_arm_i = 1; rx_cap_i = (IDX_W+1)'(cap);
        @(negedge clk);
        rx_arm_i = 0;
    endtask

    task automatic treq(input bit fill, input int len, input logic [7:0] b);
        @(negedge clk);
        tx_req_i = 1; tx_fill_i = fill; tx_len_i = (IDX_W+1)'(len); tx_byte_i = b;
        @(negedge clk);
        tx_req_i = 0;
    endtask

    // Expected receive count: bytes stored, capped at the capacity.
    function automatic int exp_rx(input int n, input int cap);
        return (n < cap) ? n : cap;
    endfunction

    // Expected NACK count: one less than loaded, floored at zero.
    function automatic int exp_nack(input int loaded);
        return (loaded > 0) ? loaded - 1 : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) txmem[i] = 8'($urandom_range(0, 255));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", ack_en_o, 0);
        chk("R1 evt", byte_evt_en_o, 0);
        chk("R1 hold", scl_hold_o, 0);
        chk("R1 pulses", {rx_done_o, tx_done_o, tx_load_o, rx_wr_en_o, tx_refused_o}, 0);

        // R3 address while idle is ignored
        ev(K_ADDR);
        chk("R3 idle addr evt", byte_evt_en_o, 0);
        // R2 arm
        arm(4);
        chk("R2 ack", ack_en_o, 1);
        chk("R2 evt", byte_evt_en_o, 0);
        ev(K_ADDR);
        chk("R3 armed addr evt", byte_evt_en_o, 1);
        // R4 store four, then overflow
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d = 8'(8'h30 + i);
            ev(K_RXB, d);
            chk("R4 wr_en", rx_wr_en_o, (i < 4) ? 1 : 0);
            if (i < 4) begin
                chk("R4 idx", rx_wr_idx_o, i);
                chk("R4 data", rx_wr_data_o, d);
            end
            chk("R4 ack", ack_en_o, (i < 4) ? 1 : 0);
        end
        // R12 stop
        ev(K_STOP);
        chk("R12 rx_done", rx_done_o, 1);
        chk("R12 count", rx_count_o, 4);
        chk("R12 ack", ack_en_o, 1);
        @(negedge clk);
        chk("R13 rx_done width", rx_done_o, 0);
        ev(K_ADDR);
        ev(K_RXB, 8'h77);
        chk("R12 offset cleared", rx_wr_idx_o, 0);
        // R8 refused while receiving
        treq(0, 2, 8'h00);
        chk("R8 refused", tx_refused_o, 1);
        chk("R8 hold", scl_hold_o, 0);
        chk("R8 ack", ack_en_o, 1);
        // R5 turnaround
        ev(K_TXE);
        chk("R5 rx_done", rx_done_o, 1);
        chk("R5 count", rx_count_o, 1);
        chk("R5 ack", ack_en_o, 0);
        chk("R5 hold", scl_hold_o, 1);
        chk("R5 evt", byte_evt_en_o, 0);
        // R6 kick packet of 3, R10 exhaustion
        treq(0, 3, 8'h00);
        chk("R6 load", tx_load_o, 1);
        chk("R6 data", tx_data_o, txmem[0]);
        chk("R6 hold", scl_hold_o, 0);
        chk("R6 evt", byte_evt_en_o, 1);
        for (int i = 1; i < 3; i++) begin
            ev(K_TXE);
            chk("R10 data", tx_data_o, txmem[i]);
        end
        ev(K_TXE);
        chk("R10 done", tx_done_o, 1);
        chk("R10 count", tx_count_o, 3);
        chk("R10 hold", scl_hold_o, 1);
        // R9 fill mode then R11 NACK
        treq(1, 0, 8'hA5);
        chk("R9 first", tx_data_o, 8'hA5);
        for (int i = 0; i < 3; i++) begin
            ev(K_TXE);
            chk("R9 load", tx_load_o, 1);
            chk("R9 data", tx_data_o, 8'hA5);
        end
        ev(K_NACK);
        chk("R11 done", tx_done_o, 1);
        chk("R11 count", tx_count_o, 3);
        chk("R11 ack", ack_en_o, 1);
        chk("R11 hold", scl_hold_o, 0);
        // R7 preload from receive-armed
        treq(0, 2, 8'h00);
        chk("R7 no load", tx_load_o, 0);
        ev(K_ADDR);
        chk("R7 evt", byte_evt_en_o, 1);
        ev(K_TXE);
        chk("R7 first load", tx_data_o, txmem[0]);
        ev(K_NACK);
        chk("R11 count one", tx_count_o, 0);
        // R10 zero-length kick
        ev(K_ADDR);
        ev(K_TXE);
        treq(0, 0, 8'h00);
        chk("R10 zero done", tx_done_o, 1);
        chk("R10 zero count", tx_count_o, 0);
        chk("R10 zero hold", scl_hold_o, 1);

        // Randomized transactions
        for (int it = 0; it < 40; it++) begin
            int cap = $urandom_range(1, 8);
            int nb = $urandom_range(0, 10);
            int st = 0;
            bit fill;
            int len, steps, loaded;
            logic [7:0] fb;
            bit active;
            arm(cap);
            ev(K_ADDR);
            for (int i = 0; i < nb; i++) begin
                logic [7:0] d = 8'($urandom_range(0, 255));
                ev(K_RXB, d);
                chk("R4 rand wr_en", rx_wr_en_o, (i < cap) ? 1 : 0);
                if (i < cap) chk("R4 rand data", rx_wr_data_o, d);
                else chk("R4 rand nack", ack_en_o, 0);
                st++;
            end
            if ($urandom_range(0, 3) == 0) begin
                ev(K_STOP);
                chk("R12 rand count", rx_count_o, exp_rx(nb, cap));
                continue;
            end
            ev(K_TXE);
            chk("R5 rand count", rx_count_o, exp_rx(nb, cap));
            chk("R5 rand hold", scl_hold_o, 1);
            fill = 1'($urandom_range(0, 1));
            len = $urandom_range(0, 5);
            fb = 8'($urandom_range(0, 255));
            treq(fill, len, fb);
            active = fill || (len > 0);
            loaded = 0;
            if (active) begin
                chk("R6 rand data", tx_data_o, fill ? fb : txmem[0]);
                loaded = 1;
            end else begin
                chk("R10 rand zero", tx_done_o, 1);
            end
            steps = $urandom_range(0, 6);
            for (int s = 0; s < steps; s++) begin
                ev(K_TXE);
                if (!active) begin
                    chk("R10 rand ignored", tx_load_o | tx_done_o, 0);
                end else if (fill || loaded < len) begin
                    chk("R9 R10 rand data", tx_data_o, fill ? fb : txmem[loaded]);
                    loaded++;
                end else begin
                    chk("R10 rand count", tx_count_o, len);
                    chk("R10 rand hold", scl_hold_o, 1);
                    active = 0;
                end
            end
            if (active) begin
                ev(K_NACK);
                chk("R11 rand count", tx_count_o, exp_nack(loaded));
                chk("R11 rand ack", ack_en_o, 1);
            end else begin
                ev(K_NACK);
                chk("R11 rand ignored", tx_done_o, 0);
                ev(K_STOP);
                chk("R12 rand tx-armed", rx_count_o, 0);
                chk("R12 rand hold", scl_hold_o, 0);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule